// File: doc/BRIEF.md
# Internal-Clock Serial Result Transmitter

This block sends a pair of 16-bit conversion results as one 32-bit serial frame. It makes its own serial clock by dividing the system clock, so it acts as the clock master on the serial link. Each word goes out most significant bit first. A configuration input chooses which channel's word leads the frame. A frame-sync output marks the whole frame and drops out briefly between the two words, so a receiver can find the word boundary.

There are two read modes. In read-after-convert mode, the sequencer's result-valid strobe starts a frame that carries the new results, and a two-bit divider code sets the serial clock rate. In read-during-convert mode, the conversion-start strobe starts a frame that carries the pair captured at the last result-valid strobe. This frame runs at the fastest rate whatever the divider code is. Polarity inputs can invert the serial clock and the frame sync. The serial outputs are enabled only while both chip select and read are low.

Top module: `ser_result_tx`

## Requirements
- R1: A frame holds 32 data bits, sent most significant bit first. The receiver samples them on the rising edges of the non-inverted serial clock. The data output changes only on the falling edges of that clock.
- R2: When `cfg_a_first` is 1 at the result-valid strobe, the frame word is {A, B}. When it is 0, the word is {B, A}.
- R3: In read-after-convert mode, each half period of the serial clock lasts 1, 2, 4 or 8 system clocks for divider codes 0, 1, 2 and 3. Every frame opens with a low half (non-inverted), and one frame lasts 64 half periods.
- R4: In read-during-convert mode, the divider code has no effect and each half period lasts one system clock.
- R5: In read-after-convert mode, `res_valid` starts a frame that carries the results present at that strobe.
- R6: In read-during-convert mode, `res_valid` only captures the results. `conv_start` starts a frame that carries the previously captured pair.
- R7: The frame sync is active from frame start to frame end. It is inactive during exactly one half period: the low half of the 17th bit. With `cfg_sync_inv`=0 the active level is high; with 1 it is low. While idle, the sync sits at its inactive level.
- R8: `cfg_sclk_inv`=1 inverts the serial clock output. The idle level of the serial clock is `cfg_sclk_inv`.
- R9: `ser_oe` is 1 only when `cs_n` and `rd_n` are both 0.
- R10: A start strobe that arrives while a frame is in progress is ignored. It neither changes the frame nor starts a later one.
- R11: After reset the block is idle: serial clock and sync at their inactive levels, and the data output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| res_valid | input | 1 | One-cycle strobe: results complete |
| conv_start | input | 1 | One-cycle strobe: a new conversion has started |
| cfg_a_first | input | 1 | 1 sends channel A first |
| cfg_sync_inv | input | 1 | 1 makes the frame sync active low |
| cfg_sclk_inv | input | 1 | 1 inverts the serial clock |
| cfg_div | input | 2 | Clock divider code (read-after-convert only) |
| cfg_rd_during | input | 1 | 1 selects read-during-convert |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk_o | output | 1 | Serial clock |
| sdout_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync |
| ser_oe | output | 1 | Output enable for the three serial outputs |

## Verification
The bench runs all four divider codes and measures each bit period from the serial clock edges. A divider decoded with the wrong shift, or one applied in read-during-convert mode, fails the period check even when the data is right. It sends frames with both channel orders and both polarities, and it counts the sync gap cycles. A design that pulses the sync at the wrong bit or for the wrong length fails that count. Other tests strobe a new start in the middle of a frame, and check that a read-during-convert frame carries the older pair rather than the one just captured. A design that restarts on the extra strobe, or that sends fresh data, leaves the expected-word queue out of step.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int DIV_W = 2;
  localparam int CNT_W = 4;

  // half-period length in system clocks; fastest rate when reading during conversion
  function automatic logic [CNT_W-1:0] half_clocks(input logic [DIV_W-1:0] div,
                                                   input logic during);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return during ? one : (one << div);
  endfunction
endpackage

// File: rtl/ser_tx_clkgen.sv
module ser_tx_clkgen
  import ser_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] half_in,
  output logic             sclk_raw,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_q;
  logic             tick;

  assign tick      = run && !load && (cnt == half_q - 1'b1);
  assign rise_tick = tick && !sclk_raw;
  assign fall_tick = tick && sclk_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sclk_raw <= 1'b0;
      half_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (load) begin
      cnt      <= '0;
      sclk_raw <= 1'b0;
      half_q   <= half_in;
    end else if (run) begin
      if (tick) begin
        cnt      <= '0;
        sclk_raw <= ~sclk_raw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt      <= '0;
      sclk_raw <= 1'b0;
    end
  end

  // R3: the held half length is always a single power of two
  assert_half_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(half_q) == 1);
  // R3: counter never passes the held half length
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half_q);
  // R1: serial clock edges only come from ticks
  assert_sclk_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && !$past(load) && $changed(sclk_raw) |-> $past(tick));
endmodule

// File: rtl/ser_tx_framer.sv
module ser_tx_framer #(
  parameter int WORD_W = 16,
  localparam int FRAME_W = 2 * WORD_W,
  localparam int IDX_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             fall_tick,
  input  logic             sclk_raw,
  output logic             active,
  output logic [IDX_W-1:0] bit_idx,
  output logic             sync_int
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] GAP_IDX  = IDX_W'(WORD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_idx <= '0;
    end else if (start_ok) begin
      active  <= 1'b1;
      bit_idx <= '0;
    end else if (fall_tick) begin
      if (bit_idx == LAST_IDX) active <= 1'b0;
      else                     bit_idx <= bit_idx + 1'b1;
    end
  end

  assign sync_int = active && !((bit_idx == GAP_IDX) && !sclk_raw);

  // R1: a frame ends only after its last bit
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(bit_idx) == LAST_IDX);
  // R1: bits advance one at a time
  assert_bit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick && !start_ok && bit_idx != LAST_IDX |=> bit_idx == $past(bit_idx) + 1'b1);
  // R10: a frame never restarts while running
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && bit_idx == '0 |-> $past(bit_idx) == '0);
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] data_in,
  output logic               msb
);
  logic [FRAME_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= data_in;
    else if (shift) sreg <= {sreg[FRAME_W-2:0], 1'b0};
  end

  assign msb = sreg[FRAME_W-1];

  // R1: contents move only on load or on a falling tick
  assert_shift_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(sreg));
endmodule

// File: rtl/ser_result_tx.sv
module ser_result_tx
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int FRAME_W = 2 * WORD_W,
  localparam int IDX_W = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  logic              res_valid,
  input  logic              conv_start,
  input  logic              cfg_a_first,
  input  logic              cfg_sync_inv,
  input  logic              cfg_sclk_inv,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_rd_during,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic              sclk_o,
  output logic              sdout_o,
  output logic              sync_o,
  output logic              ser_oe
);
  logic [FRAME_W-1:0] pair_now;
  logic [FRAME_W-1:0] hold_q;
  logic [FRAME_W-1:0] load_data;
  logic               start_req;
  logic               start_ok;
  logic               active;
  logic [IDX_W-1:0]   bit_idx;
  logic               sync_int;
  logic               sclk_raw;
  logic               rise_tick;
  logic               fall_tick;
  logic               msb;
  logic [CNT_W-1:0]   half_sel;

  assign pair_now  = cfg_a_first ? {res_a, res_b} : {res_b, res_a};
  assign start_req = cfg_rd_during ? conv_start : res_valid;
  assign start_ok  = start_req && !active;
  assign load_data = cfg_rd_during ? hold_q : pair_now;
  assign half_sel  = half_clocks(cfg_div, cfg_rd_during);

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '0;
    else if (res_valid) hold_q <= pair_now;
  end

  ser_tx_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .run(active),
    .half_in(half_sel), .sclk_raw(sclk_raw),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  ser_tx_framer #(.WORD_W(WORD_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .fall_tick(fall_tick),
    .sclk_raw(sclk_raw), .active(active), .bit_idx(bit_idx), .sync_int(sync_int)
  );

  ser_tx_shifter #(.FRAME_W(FRAME_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .shift(fall_tick),
    .data_in(load_data), .msb(msb)
  );

  assign sclk_o  = sclk_raw ^ cfg_sclk_inv;
  assign sync_o  = sync_int ^ cfg_sync_inv;
  assign sdout_o = active & msb;
  assign ser_oe  = !cs_n && !rd_n;

  // R1: data is steady across a rising serial clock edge
  assert_data_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start_ok && !$past(fall_tick) && $past(active) |-> $stable(msb));
  // R7: the sync drops only while a frame runs with the clock low
  assert_sync_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && !sync_int |-> !sclk_raw);
  // R11: idle means serial clock low
  assert_idle_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_raw);
  // R6: in read-during-convert mode a capture alone never starts a frame
  assert_capture_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_during && !conv_start && !active |=> !active);
endmodule

// File: tb/tb_ser_result_tx.sv
module tb_ser_result_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] res_a = '0, res_b = '0;
  logic        res_valid = 1'b0, conv_start = 1'b0;
  logic        cfg_a_first = 1'b1, cfg_sync_inv = 1'b0, cfg_sclk_inv = 1'b0;
  logic [1:0]  cfg_div = 2'd0;
  logic        cfg_rd_during = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1;
  logic        sclk_o, sdout_o, sync_o, ser_oe;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] q_word[$];
  int          q_half[$];

  always #2.5 clk = ~clk;

  ser_result_tx dut (
    .clk(clk), .rst_n(rst_n), .res_a(res_a), .res_b(res_b),
    .res_valid(res_valid), .conv_start(conv_start),
    .cfg_a_first(cfg_a_first), .cfg_sync_inv(cfg_sync_inv),
    .cfg_sclk_inv(cfg_sclk_inv), .cfg_div(cfg_div),
    .cfg_rd_during(cfg_rd_during), .cs_n(cs_n), .rd_n(rd_n),
    .sclk_o(sclk_o), .sdout_o(sdout_o), .sync_o(sync_o), .ser_oe(ser_oe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: rebuilds frames from the pins and compares with the queue
  logic        prev_sc = 1'b0;
  int          nbits = 0, cyc = 0, gap = 0;
  bit          period_bad = 0, sync_bad = 0;
  logic [31:0] got = '0;

  always @(negedge clk) begin
    logic sc, sa;
    sc = sclk_o ^ cfg_sclk_inv;
    sa = sync_o ^ cfg_sync_inv;
    if (rst_n && ser_oe) begin
      cyc++;
      if (nbits >= 1 && nbits < 32 && !sa) gap++;
      if (sc && !prev_sc) begin
        if (!sa) sync_bad = 1;
        got = {got[30:0], sdout_o};
        if (nbits >= 1 && q_half.size() > 0 && cyc != 2 * q_half[0]) period_bad = 1;
        cyc = 0;
        nbits++;
        if (nbits == 32) begin
          if (q_word.size() == 0) begin
            chk(0, "R10 unexpected frame", got, 0);
          end else begin
            int h;
            logic [31:0] w;
            w = q_word.pop_front();
            h = q_half.pop_front();
            chk(got == w, "R1/R2 frame word", got, w);
            chk(!period_bad, "R3/R4 bit period", 0, 2 * h);
            chk(gap == h, "R7 sync gap length", gap, h);
            chk(!sync_bad, "R7 sync active at sampling edges", 1, 0);
          end
          nbits = 0; gap = 0; period_bad = 0; sync_bad = 0;
        end
      end
      prev_sc = sc;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_valid(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // read-after-convert frame: driver pushes the expectation then strobes
  task automatic send_after(input logic [15:0] a, input logic [15:0] b,
                            input logic af, input logic [1:0] div);
    int h;
    cfg_rd_during = 1'b0; cfg_a_first = af; cfg_div = div;
    h = 1 << div;
    q_word.push_back(af ? {a, b} : {b, a});
    q_half.push_back(h);
    pulse_valid(a, b);
    wait_cyc(64 * h + 6);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(ser_oe == 1'b0, "R9 deselected after reset", ser_oe, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    wait_cyc(1);
    chk(ser_oe == 1'b1, "R9 enabled with cs and rd low", ser_oe, 1);
    chk(sclk_o == 1'b0 && sync_o == 1'b0 && sdout_o == 1'b0, "R11 reset idle levels",
        {sclk_o, sync_o, sdout_o}, 0);

    // R3 R1 R2 R5: each divider code, both orders
    send_after(16'hA5C3, 16'h1234, 1'b1, 2'd0);
    send_after(16'h8001, 16'hFFFE, 1'b0, 2'd1);
    send_after(16'h0F0F, 16'hF00F, 1'b1, 2'd2);
    send_after(16'h7E81, 16'h3C00, 1'b0, 2'd3);

    // R7 R8: inverted polarities, idle levels first
    cfg_sync_inv = 1'b1; cfg_sclk_inv = 1'b1;
    wait_cyc(2);
    chk(sclk_o == 1'b1, "R8 inverted idle clock", sclk_o, 1);
    chk(sync_o == 1'b1, "R7 inverted idle sync", sync_o, 1);
    send_after(16'hDEAD, 16'hBEEF, 1'b0, 2'd1);
    cfg_sync_inv = 1'b0; cfg_sclk_inv = 1'b0;
    wait_cyc(2);

    // R10: extra strobe mid-frame is ignored
    cfg_rd_during = 1'b0; cfg_a_first = 1'b1; cfg_div = 2'd2;
    q_word.push_back({16'h1357, 16'h2468});
    q_half.push_back(4);
    pulse_valid(16'h1357, 16'h2468);
    wait_cyc(60);
    pulse_valid(16'hFFFF, 16'h0000);
    wait_cyc(64 * 4 + 10);
    chk(q_word.size() == 0, "R10 frame completed unchanged", q_word.size(), 0);

    // R4 R6: read-during-convert sends the earlier pair at full rate
    cfg_rd_during = 1'b1; cfg_div = 2'd3; cfg_a_first = 1'b1;
    pulse_valid(16'h4321, 16'h8765);
    wait_cyc(20);
    chk(ser_oe && sync_o == 1'b0, "R6 capture alone starts no frame", sync_o, 0);
    q_word.push_back({16'h4321, 16'h8765});
    q_half.push_back(1);
    @(negedge clk); conv_start = 1'b1;
    res_a = 16'h9999; res_b = 16'h6666; res_valid = 1'b1;
    @(negedge clk); conv_start = 1'b0; res_valid = 1'b0;
    wait_cyc(80);
    q_word.push_back({16'h9999, 16'h6666});
    q_half.push_back(1);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    wait_cyc(80);
    chk(q_word.size() == 0, "R6 all during-convert frames seen", q_word.size(), 0);

    // R9: read high alone disables the outputs
    rd_n = 1'b1;
    wait_cyc(1);
    chk(ser_oe == 1'b0, "R9 read high disables", ser_oe, 0);
    rd_n = 1'b0; cs_n = 1'b1;
    wait_cyc(1);
    chk(ser_oe == 1'b0, "R9 chip select high disables", ser_oe, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule